// File: doc/BRIEF.md
# Synthesizer Divider, Phase Detector and Pump Control Core

This block holds the digital heart of a PLL frequency synthesizer. A 15-bit programmable counter divides the prescaled VCO strobe. A second counter divides the crystal strobe by one of three fixed ratios. A two-flip-flop phase/frequency detector turns the two terminal-count pulses into pump-up and pump-down enables.

A lock detector measures the one-sided pump activity in every comparison interval and declares lock after a run of clean intervals. The lock state drives an active-low lock pin and an in-lock flag. It also drives an automatic switch that forces the pump current low once the loop has settled, and a flag reports that switch.

All register values arrive as inputs from a separate control interface. A three-bit test field can override the pump. It can also put the divided reference, or half the divided VCO signal, on the lock pin. Both input clocks appear as single-cycle enable strobes in the core clock domain.

Top module: `syn_core`

## Requirements
- R1: `div_tc` pulses once every `div_n` rising `vco_en` strobes. A `div_n` of 0 behaves as 1. Half of this rate is observable as a toggle in test mode 101.
- R2: The reference divides `ref_en` strobes as follows: `ratio_b`=0 gives 640 for either `ratio_a`; `ratio_a`=0 with `ratio_b`=1 gives 1024; `ratio_a`=1 with `ratio_b`=1 gives 512.
- R3: A reference terminal count sets `pump_up` and a divider terminal count sets `pump_dn`, each in the following cycle. When both are high they stay high together for exactly one cycle and then clear.
- R4: `in_lock` goes to 1 at the fourth consecutive reference comparison whose one-sided pump cycle count did not exceed `lock_win`.
- R5: As soon as the running one-sided count of the current interval exceeds `lock_win`, `in_lock` clears on the next cycle and the run of clean intervals restarts.
- R6: `acps` is 0 only when `test_mode`=000 and `in_lock`=1, and is 1 otherwise. `pump_hi` equals `cp_high` while `acps`=1 and is 0 while `acps`=0.
- R7: `test_mode` 010 and 011 hold both pump outputs at 0. Mode 110 gives `pump_dn`=1 and `pump_up`=0. Mode 111 gives `pump_up`=1 and `pump_dn`=0. All other modes pass the detector outputs through.
- R8: `lock_pin` equals NOT `in_lock`, except in two test modes. In mode 100 it carries the one-cycle reference terminal pulse. In mode 101 it carries a flop that toggles on each divider terminal pulse.
- R9: `tune_oe` is the inverse of `tune_off`.
- R10: While `rst` is high and in the first cycle after it: `pump_up`=`pump_dn`=0, `in_lock`=0 and `acps`=1. With `test_mode`=001, `lock_pin`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_en | input | 1 | Crystal clock strobe |
| vco_en | input | 1 | Prescaled VCO strobe |
| div_n | input | 15 | Main divider ratio, bit 14 is the MSB |
| ratio_a | input | 1 | Reference ratio select, first bit |
| ratio_b | input | 1 | Reference ratio select, second bit |
| cp_high | input | 1 | Pump current request: 1 high, 0 low |
| test_mode | input | 3 | Test field, decoded as in R6, R7 and R8 |
| tune_off | input | 1 | 1 disables the tuning output |
| lock_win | input | 8 | Largest one-sided pump count per interval still treated as clean |
| pump_up | output | 1 | Pump source enable |
| pump_dn | output | 1 | Pump sink enable |
| pump_hi | output | 1 | Pump current select: 1 high, 0 low |
| acps | output | 1 | Auto-switch flag, 0 when the current is forced low |
| in_lock | output | 1 | In-lock flag |
| lock_pin | output | 1 | Active-low lock indication, or a test signal |
| tune_oe | output | 1 | Tuning output enable |

## Verification
The hardest state to reach is a loss of lock after a stable lock. It needs four clean comparison intervals first, and then a phase error that builds up over real divider periods. The bench drives both strobes on every cycle with a 512 reference and N=512, so the two terminal counts coincide and lock is reached. It then switches N to 500, which makes the divider run ahead by twelve cycles per interval. A behavioural model follows the pump, lock and pin outputs on every cycle through this drift. Directed period measurements on the lock pin confirm the divider ratios.

// File: rtl/syn_pkg.sv
package syn_pkg;
    localparam int N_W   = 15;
    localparam int REF_W = 10;
    localparam int ERR_W = 8;

    typedef enum logic [2:0] {
        TM_AUTO   = 3'b000,
        TM_MANUAL = 3'b001,
        TM_OFF_A  = 3'b010,
        TM_OFF_B  = 3'b011,
        TM_REFPIN = 3'b100,
        TM_HALFPN = 3'b101,
        TM_SINK   = 3'b110,
        TM_SOURCE = 3'b111
    } test_mode_e;

    typedef struct packed {
        logic up;
        logic dn;
    } pump_t;

    // terminal count (ratio - 1) of the reference divider
    function automatic logic [REF_W-1:0] ref_term(input logic sel_a, input logic sel_b);
        if (!sel_b)     return REF_W'(639);
        else if (!sel_a) return REF_W'(1023);
        else            return REF_W'(511);
    endfunction
endpackage

// File: rtl/syn_prog_div.sv
module syn_prog_div #(
    parameter int W = 15
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic [W-1:0] term,
    output logic         tc
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            tc  <= 1'b0;
        end else if (en) begin
            if (cnt >= term) begin
                cnt <= '0;
                tc  <= 1'b1;
            end else begin
                cnt <= cnt + 1'b1;
                tc  <= 1'b0;
            end
        end else begin
            tc <= 1'b0;
        end
    end

    AST_TC_AFTER_TICK: assert property (@(posedge clk) disable iff (rst)
        tc |-> $past(en)); // R1
endmodule

// File: rtl/syn_pfd.sv
module syn_pfd (
    input  logic clk,
    input  logic rst,
    input  logic ref_tc,
    input  logic div_tc,
    output logic up,
    output logic dn
);
    logic clr;
    assign clr = up & dn;

    always_ff @(posedge clk) begin
        if (rst) begin
            up <= 1'b0;
            dn <= 1'b0;
        end else if (clr) begin
            up <= ref_tc;
            dn <= div_tc;
        end else begin
            up <= up | ref_tc;
            dn <= dn | div_tc;
        end
    end

    AST_PFD_SINGLE_OVERLAP: assert property (@(posedge clk) disable iff (rst)
        (up && dn && !(ref_tc && div_tc)) |=> !(up && dn)); // R3
endmodule

// File: rtl/syn_lock_det.sv
module syn_lock_det #(
    parameter int ERR_W       = 8,
    parameter int LOCK_CYCLES = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ref_tc,
    input  logic             up,
    input  logic             dn,
    input  logic [ERR_W-1:0] win,
    output logic             locked
);
    localparam int GW = $clog2(LOCK_CYCLES + 1);

    logic [ERR_W-1:0] err;
    logic [GW-1:0]    good;
    logic             big;

    assign big = err > win;

    always_ff @(posedge clk) begin
        if (rst || ref_tc)
            err <= '0;
        else if ((up ^ dn) && err != '1)
            err <= err + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst || big)
            good <= '0;
        else if (ref_tc && good != GW'(LOCK_CYCLES))
            good <= good + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst || big)
            locked <= 1'b0;
        else if (ref_tc && good == GW'(LOCK_CYCLES - 1))
            locked <= 1'b1;
    end

    AST_LOCK_ON_COMPARE: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> $past(ref_tc)); // R4
    AST_LOCK_DROP: assert property (@(posedge clk) disable iff (rst)
        big |=> !locked); // R5
endmodule

// File: rtl/syn_core.sv
module syn_core
    import syn_pkg::*;
#(
    parameter int LOCK_CYCLES = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ref_en,
    input  logic             vco_en,
    input  logic [N_W-1:0]   div_n,
    input  logic             ratio_a,
    input  logic             ratio_b,
    input  logic             cp_high,
    input  logic [2:0]       test_mode,
    input  logic             tune_off,
    input  logic [ERR_W-1:0] lock_win,
    output logic             pump_up,
    output logic             pump_dn,
    output logic             pump_hi,
    output logic             acps,
    output logic             in_lock,
    output logic             lock_pin,
    output logic             tune_oe
);
    logic [N_W-1:0] div_term;
    logic           div_tc, ref_tc, half_q;
    pump_t          pfd_q, pump_o;
    test_mode_e     tm;

    assign tm       = test_mode_e'(test_mode);
    assign div_term = (div_n == '0) ? '0 : div_n - 1'b1;

    syn_prog_div #(.W(N_W)) u_main_div (
        .clk(clk), .rst(rst), .en(vco_en), .term(div_term), .tc(div_tc)
    );

    syn_prog_div #(.W(REF_W)) u_ref_div (
        .clk(clk), .rst(rst), .en(ref_en), .term(ref_term(ratio_a, ratio_b)), .tc(ref_tc)
    );

    syn_pfd u_pfd (
        .clk(clk), .rst(rst), .ref_tc(ref_tc), .div_tc(div_tc),
        .up(pfd_q.up), .dn(pfd_q.dn)
    );

    syn_lock_det #(.ERR_W(ERR_W), .LOCK_CYCLES(LOCK_CYCLES)) u_lock (
        .clk(clk), .rst(rst), .ref_tc(ref_tc), .up(pfd_q.up), .dn(pfd_q.dn),
        .win(lock_win), .locked(in_lock)
    );

    always_ff @(posedge clk) begin
        if (rst)
            half_q <= 1'b0;
        else if (div_tc)
            half_q <= ~half_q;
    end

    always_comb begin
        pump_o   = pfd_q;
        lock_pin = ~in_lock;
        unique case (tm)
            TM_OFF_A, TM_OFF_B: pump_o = '{up: 1'b0, dn: 1'b0};
            TM_SINK:            pump_o = '{up: 1'b0, dn: 1'b1};
            TM_SOURCE:          pump_o = '{up: 1'b1, dn: 1'b0};
            TM_REFPIN:          lock_pin = ref_tc;
            TM_HALFPN:          lock_pin = half_q;
            default:            ;
        endcase
    end

    assign pump_up = pump_o.up;
    assign pump_dn = pump_o.dn;
    assign acps    = ~((tm == TM_AUTO) & in_lock);
    assign pump_hi = cp_high & acps;
    assign tune_oe = ~tune_off;

    AST_ACPS_RISE_ON_UNLOCK: assert property (@(posedge clk) disable iff (rst)
        (tm == TM_AUTO && $past(tm) == TM_AUTO && $rose(acps)) |-> $past(in_lock)); // R6
    AST_HALF_HOLD: assert property (@(posedge clk) disable iff (rst)
        (tm == TM_HALFPN && $past(tm) == TM_HALFPN && !$past(div_tc)) |-> $stable(lock_pin)); // R8
endmodule

// File: tb/syn_core_tb.sv
`timescale 1ns/100ps
module syn_core_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ref_en = 1'b1, vco_en = 1'b1;
    logic [14:0] div_n = 15'd512;
    logic        ratio_a = 1'b1, ratio_b = 1'b1, cp_high = 1'b1, tune_off = 1'b0;
    logic [2:0]  test_mode = 3'b001;
    logic [7:0]  lock_win = 8'd8;
    logic        pump_up, pump_dn, pump_hi, acps, in_lock, lock_pin, tune_oe;

    int checks = 0, errors = 0;
    bit vco_alt = 1'b0;
    bit done = 1'b0;

    syn_core u_dut (.*);

    always #2.5 clk = ~clk;

    // behavioural reference state
    int m_dcnt, m_rcnt, m_err, m_good;
    bit m_dtc, m_rtc, m_up, m_dn, m_lock, m_half;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        int dterm, rterm, n_dcnt, n_rcnt, n_err, n_good;
        bit n_dtc, n_rtc, n_up, n_dn, n_lock, n_half, big;
        if (rst) begin
            m_dcnt = 0; m_rcnt = 0; m_err = 0; m_good = 0;
            m_dtc = 0; m_rtc = 0; m_up = 0; m_dn = 0; m_lock = 0; m_half = 0;
        end else begin
            dterm = (div_n == 0) ? 0 : int'(div_n) - 1;
            rterm = !ratio_b ? 639 : (!ratio_a ? 1023 : 511);
            n_dcnt = m_dcnt; n_dtc = 0;
            if (vco_en) begin
                if (m_dcnt >= dterm) begin n_dcnt = 0; n_dtc = 1; end
                else n_dcnt = m_dcnt + 1;
            end
            n_rcnt = m_rcnt; n_rtc = 0;
            if (ref_en) begin
                if (m_rcnt >= rterm) begin n_rcnt = 0; n_rtc = 1; end
                else n_rcnt = m_rcnt + 1;
            end
            if (m_up && m_dn) begin n_up = m_rtc; n_dn = m_dtc; end
            else begin n_up = m_up || m_rtc; n_dn = m_dn || m_dtc; end
            if (m_rtc) n_err = 0;
            else if ((m_up != m_dn) && m_err < 255) n_err = m_err + 1;
            else n_err = m_err;
            big = m_err > int'(lock_win);
            n_good = big ? 0 : ((m_rtc && m_good < 4) ? m_good + 1 : m_good);
            n_lock = big ? 0 : ((m_rtc && m_good == 3) ? 1 : m_lock);
            n_half = m_dtc ? !m_half : m_half;
            m_dcnt = n_dcnt; m_rcnt = n_rcnt; m_err = n_err; m_good = n_good;
            m_dtc = n_dtc; m_rtc = n_rtc; m_up = n_up; m_dn = n_dn; m_lock = n_lock; m_half = n_half;
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        bit e_up, e_dn, e_acps, e_pin;
        if (!rst && !done) begin
            e_up = m_up; e_dn = m_dn;
            case (test_mode)
                3'b010, 3'b011: begin e_up = 0; e_dn = 0; end
                3'b110: begin e_up = 0; e_dn = 1; end
                3'b111: begin e_up = 1; e_dn = 0; end
                default: ;
            endcase
            e_acps = !(test_mode == 3'b000 && m_lock);
            e_pin  = (test_mode == 3'b100) ? m_rtc : ((test_mode == 3'b101) ? m_half : !m_lock);
            chk(pump_up == e_up, "R3/R7", "pump_up", pump_up, e_up);
            chk(pump_dn == e_dn, "R3/R7", "pump_dn", pump_dn, e_dn);
            chk(in_lock == m_lock, "R4/R5", "in_lock", in_lock, m_lock);
            chk(acps == e_acps, "R6", "acps", acps, e_acps);
            chk(pump_hi == (cp_high && e_acps), "R6", "pump_hi", pump_hi, cp_high && e_acps);
            chk(lock_pin == e_pin, "R8", "lock_pin", lock_pin, e_pin);
            chk(tune_oe == !tune_off, "R9", "tune_oe", tune_oe, !tune_off);
        end
    end

    initial begin
        forever begin
            @(negedge clk);
            #1 vco_en = vco_alt ? ~vco_en : 1'b1;
        end
    end

    task automatic cyc(input int k);
        repeat (k) @(negedge clk);
    endtask

    // cycles between successive rising edges of lock_pin (second interval)
    task automatic rise_period(output int p);
        int c = 0;
        bit prev = lock_pin;
        int seen = 0;
        p = 0;
        while (seen < 3 && c < 5000) begin
            @(negedge clk);
            c++;
            if (lock_pin && !prev) begin
                seen++;
                if (seen == 2) c = 0;
                if (seen == 3) p = c;
            end
            prev = lock_pin;
        end
    endtask

    // cycles between successive changes of lock_pin (second interval)
    task automatic toggle_period(output int p);
        int c = 0;
        bit prev = lock_pin;
        int seen = 0;
        p = 0;
        while (seen < 3 && c < 5000) begin
            @(negedge clk);
            c++;
            if (lock_pin != prev) begin
                seen++;
                if (seen == 2) c = 0;
                if (seen == 3) p = c;
            end
            prev = lock_pin;
        end
    endtask

    initial begin
        int p;
        cyc(3);
        // R10: outputs during reset
        chk(pump_up == 0 && pump_dn == 0, "R10", "pump in reset", {pump_up, pump_dn}, 0);
        chk(in_lock == 0 && acps == 1, "R10", "lock/acps in reset", {in_lock, acps}, 1);
        chk(lock_pin == 1, "R10", "lock_pin in reset", lock_pin, 1);
        #1 rst = 1'b0;
        cyc(1);
        chk(pump_up == 0 && pump_dn == 0 && in_lock == 0, "R10", "first cycle", {pump_up, pump_dn, in_lock}, 0);

        // R4: aligned 512/512 loop reaches lock
        cyc(4000);
        chk(in_lock == 1, "R4", "in_lock after aligned run", in_lock, 1);
        chk(lock_pin == 0, "R8", "lock_pin when locked", lock_pin, 0);
        chk(pump_hi == 1, "R6", "pump_hi manual mode", pump_hi, 1);
        #1 test_mode = 3'b000;
        cyc(1);
        chk(acps == 0, "R6", "acps auto+lock", acps, 0);
        chk(pump_hi == 0, "R6", "pump_hi forced low", pump_hi, 0);

        // R5: divider runs ahead, lock is lost
        #1 div_n = 15'd500;
        cyc(1200);
        chk(in_lock == 0, "R5", "in_lock after drift", in_lock, 0);
        chk(acps == 1 && pump_hi == 1, "R6", "acps/pump_hi unlocked", {acps, pump_hi}, 3);
        #1 cp_high = 1'b0; test_mode = 3'b001;
        cyc(1);
        chk(pump_hi == 0, "R6", "pump_hi with cp low", pump_hi, 0);

        // R2: reference ratios seen on lock_pin in mode 100
        #1 test_mode = 3'b100; ratio_b = 1'b0; ratio_a = 1'b1;
        rise_period(p);
        chk(p == 640, "R2", "ref period b=0", p, 640);
        #1 ratio_a = 1'b0; ratio_b = 1'b1;
        rise_period(p);
        chk(p == 1024, "R2", "ref period a=0 b=1", p, 1024);
        #1 ratio_a = 1'b1;
        rise_period(p);
        chk(p == 512, "R2", "ref period a=1 b=1", p, 512);

        // R1: divider observed through half-rate toggle in mode 101
        #1 test_mode = 3'b101; div_n = 15'd100; vco_alt = 1'b1;
        toggle_period(p);
        chk(p == 200, "R1", "toggle interval N=100", p, 200);
        #1 div_n = 15'd0;
        toggle_period(p);
        chk(p == 2, "R1", "toggle interval N=0", p, 2);
        #1 div_n = 15'd7; vco_alt = 1'b0;
        toggle_period(p);
        chk(p == 7, "R1", "toggle interval N=7", p, 7);

        // R7: pump overrides
        #1 test_mode = 3'b010;
        cyc(2);
        chk(pump_up == 0 && pump_dn == 0, "R7", "mode 010", {pump_up, pump_dn}, 0);
        #1 test_mode = 3'b011;
        cyc(2);
        chk(pump_up == 0 && pump_dn == 0, "R7", "mode 011", {pump_up, pump_dn}, 0);
        #1 test_mode = 3'b110;
        cyc(2);
        chk(pump_up == 0 && pump_dn == 1, "R7", "mode 110", {pump_up, pump_dn}, 1);
        #1 test_mode = 3'b111;
        cyc(2);
        chk(pump_up == 1 && pump_dn == 0, "R7", "mode 111", {pump_up, pump_dn}, 2);

        // R9: tuning output enable
        #1 tune_off = 1'b1;
        cyc(1);
        chk(tune_oe == 0, "R9", "tune_oe off", tune_oe, 0);
        #1 tune_off = 1'b0;
        cyc(1);
        chk(tune_oe == 1, "R9", "tune_oe on", tune_oe, 1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog run did not complete actual=1 expected=0");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule